// File: doc/BRIEF.md
# Unaligned Partial Store Byte Sequencer

This block turns one partial-word store request into a short stream of single-byte memory writes. A request carries a register value, an effective byte address and three mode bits. The first selects a 4-byte or an 8-byte variant. The second selects big- or little-endian byte order. The third selects the left-hand form, which starts from the most significant byte, or the right-hand form, which starts from the least significant byte. The block works out how many bytes the store covers, which register byte goes out first, and whether the write address climbs or falls.

Each byte write leaves on a valid/ready channel, one byte per accepted cycle. After the last byte is taken, the block raises a one-cycle completion pulse. A new request is taken only while the sequencer is idle. Address translation, fault handling and merging bytes into a wide bus belong to the surrounding load/store unit.

Top module: `store_lane_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_valid` and `done` are 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only when no byte stream is in progress. A request offered while `req_ready` is 0 is ignored and leaves the current stream unchanged. An accepted request makes `wr_valid` 1 in the next cycle.
- R3: For the 4-byte variant (`req_dword`=0), the mask is 3 and the offset is `req_addr[1:0]`. In little-endian mode (`req_big`=0) the offset is XORed with 3. A left store emits 4 − offset bytes and a right store emits offset + 1 bytes.
- R4: For the 8-byte variant (`req_dword`=1), the mask is 7 and the offset is `req_addr[2:0]`. In little-endian mode the offset is XORed with 7. A left store emits 8 − offset bytes and a right store emits offset + 1 bytes.
- R5: A left store (`req_left`=1) emits register bytes from the variant's most significant byte downward. For the 4-byte variant that byte is bits 31:24; for the 8-byte variant it is bits 63:56. The 4-byte variant never emits bits 63:32.
- R6: A right store (`req_left`=0) emits register bytes from bits 7:0 upward.
- R7: The first write goes to `req_addr`. The step is +1 in big-endian mode and −1 in little-endian mode. Write k of a left store goes to `req_addr` + k·step; write k of a right store goes to `req_addr` − k·step.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, the block holds `wr_valid`, `wr_addr` and `wr_byte` unchanged. Each cycle with both high transfers exactly one byte.
- R9: `done` is a single-cycle pulse in the cycle after the final byte's handshake. `wr_valid` is 0 while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Store request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_data | input | 64 | Register value to store |
| req_addr | input | ADDR_W | Effective byte address |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian |
| req_dword | input | 1 | 1 = 8-byte variant, 0 = 4-byte variant |
| req_left | input | 1 | 1 = left store, 0 = right store |
| wr_valid | output | 1 | Byte write pending |
| wr_ready | input | 1 | Memory side takes the byte |
| wr_addr | output | ADDR_W | Byte write address |
| wr_byte | output | 8 | Byte write data |
| done | output | 1 | Pulse after the final byte |

## Verification
The bench builds the block with the default ADDR_W of 32. At that width, addresses near zero and near the top of the range take exact values, so a step in the wrong direction shows up as a clearly wrong address. A sweep covers every offset for both variants, both byte orders and both directions. This reaches every byte count from 1 to 8 and both address directions under each endianness. Directed runs also throttle `wr_ready` to exercise holding, and offer a competing request in mid-stream.

// File: rtl/sl_pkg.sv
package sl_pkg;
    localparam int MAX_BYTES = 8;
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam int DATA_W    = 8 * MAX_BYTES;

    typedef enum logic {SL_IDLE, SL_BUSY} sl_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              left;
        logic              up;
        logic [IDX_W-1:0]  mask;
        logic [IDX_W-1:0]  last;
    } sl_job_t;

    function automatic logic [IDX_W-1:0] lane_mask(input logic dword);
        return dword ? IDX_W'(7) : IDX_W'(3);
    endfunction

    function automatic logic [IDX_W-1:0] lane_offset(input logic [IDX_W-1:0] lo,
                                                     input logic dword,
                                                     input logic big);
        logic [IDX_W-1:0] m;
        m = lane_mask(dword);
        return big ? (lo & m) : ((lo & m) ^ m);
    endfunction
endpackage

// File: rtl/sl_lane_calc.sv
module sl_lane_calc
    import sl_pkg::*;
(
    input  logic [IDX_W-1:0] addr_lo,
    input  logic             dword,
    input  logic             big,
    input  logic             left,
    output logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] last,
    output logic             up
);
    logic [IDX_W-1:0] off;

    always_comb begin
        mask = lane_mask(dword);
        off  = lane_offset(addr_lo, dword, big);
        last = left ? (mask - off) : off;
        // climbing addresses when the step sign and the direction sign agree
        up   = (left == big);
    end
endmodule

// File: rtl/sl_seq.sv
module sl_seq
    import sl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] last,
    input  logic             wr_ready,
    output logic             busy,
    output logic [IDX_W-1:0] k,
    output logic             done
);
    sl_state_e state;

    assign busy = (state == SL_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SL_IDLE;
            k     <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SL_IDLE: begin
                    if (start) begin
                        state <= SL_BUSY;
                        k     <= '0;
                    end
                end
                SL_BUSY: begin
                    if (wr_ready) begin
                        if (k == last) begin
                            state <= SL_IDLE;
                            done  <= 1'b1;
                        end else begin
                            k <= k + 1'b1;
                        end
                    end
                end
                default: state <= SL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sl_byte_pick.sv
module sl_byte_pick
    import sl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  sl_job_t           job,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  k,
    output logic [7:0]        byte_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx    = job.left ? (job.mask - k) : k;
        byte_o = job.data[{idx, 3'b000} +: 8];
        addr_o = job.up ? (base + ADDR_W'(k)) : (base - ADDR_W'(k));
    end
endmodule

// File: rtl/store_lane_gen.sv
module store_lane_gen
    import sl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_big,
    input  logic              req_dword,
    input  logic              req_left,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_byte,
    output logic              done
);
    logic             busy;
    logic             start;
    logic [IDX_W-1:0] k;
    logic [IDX_W-1:0] c_mask, c_last;
    logic             c_up;
    sl_job_t          job;
    logic [ADDR_W-1:0] base;

    assign req_ready = !busy;
    assign start     = req_valid && req_ready;
    assign wr_valid  = busy;

    sl_lane_calc u_calc (
        .addr_lo (req_addr[IDX_W-1:0]),
        .dword   (req_dword),
        .big     (req_big),
        .left    (req_left),
        .mask    (c_mask),
        .last    (c_last),
        .up      (c_up)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            job  <= '0;
            base <= '0;
        end else if (start) begin
            job.data <= req_data;
            job.left <= req_left;
            job.up   <= c_up;
            job.mask <= c_mask;
            job.last <= c_last;
            base     <= req_addr;
        end
    end

    sl_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .last     (job.last),
        .wr_ready (wr_ready),
        .busy     (busy),
        .k        (k),
        .done     (done)
    );

    sl_byte_pick #(.ADDR_W(ADDR_W)) u_pick (
        .job    (job),
        .base   (base),
        .k      (k),
        .byte_o (wr_byte),
        .addr_o (wr_addr)
    );
endmodule

// File: rtl/store_lane_gen_chk.sv
module store_lane_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_byte,
    input logic              done
);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_byte)));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (!wr_valid ||
            (wr_addr == $past(wr_addr) + ADDR_W'(1)) ||
            (wr_addr == $past(wr_addr) - ADDR_W'(1))));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_valid && wr_ready) && !wr_valid));

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> wr_valid);
endmodule

bind store_lane_gen store_lane_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_byte   (wr_byte),
    .done      (done)
);

// File: tb/store_lane_gen_tb.sv
module store_lane_gen_tb;
    localparam int ADDR_W = 32;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [63:0]       req_data = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_big = 1'b0;
    logic              req_dword = 1'b0;
    logic              req_left = 1'b0;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_byte;
    logic              done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_lane_gen #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data), .req_addr(req_addr), .req_big(req_big),
        .req_dword(req_dword), .req_left(req_left), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One request, with optional back-pressure and optional competing request.
    task automatic run_job(input logic [63:0] data, input logic [ADDR_W-1:0] addr,
                           input bit big, input bit dword, input bit left,
                           input bit stall, input bit poke, input string rq);
        int m, off, n, got, cyc, idx, step;
        bit prev_last, held;
        logic [7:0] hb;
        logic [ADDR_W-1:0] ha, ea;
        m    = dword ? 7 : 3;
        off  = int'(addr) & m;
        if (!big) off = off ^ m;
        n    = left ? (m - off + 1) : (off + 1);
        step = big ? 1 : -1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 idle ready", 64'(req_ready), 64'd1);
        req_data = data; req_addr = addr; req_big = big;
        req_dword = dword; req_left = left; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid = 1'b1; req_data = ~data; req_addr = addr + 32'h100;
            req_left = ~left;
            chk(req_ready == 1'b0, "R2 busy not ready", 64'(req_ready), 64'd0);
        end
        got = 0; cyc = 0; prev_last = 0; held = 0; hb = '0; ha = '0;
        while (cyc < 60) begin
            chk(done == prev_last, {rq, "/R9 done timing"}, 64'(done), 64'(prev_last));
            if (done) begin
                chk(wr_valid == 1'b0, "R9 idle at done", 64'(wr_valid), 64'd0);
                break;
            end
            if (held)
                chk(wr_valid && wr_byte == hb && wr_addr == ha, "R8 hold",
                    {wr_byte, wr_addr}, {hb, ha});
            wr_ready = stall ? (cyc % 3 != 1) : 1'b1;
            prev_last = 0; held = 0;
            if (wr_valid) begin
                if (wr_ready) begin
                    if (got < n) begin
                        idx = left ? (m - got) : got;
                        ea  = left ? addr + ADDR_W'(got * step) : addr - ADDR_W'(got * step);
                        chk(wr_byte == data[idx*8 +: 8], {rq, left ? "/R5 byte" : "/R6 byte"},
                            64'(wr_byte), 64'(data[idx*8 +: 8]));
                        chk(wr_addr == ea, "R7 addr", 64'(wr_addr), 64'(ea));
                    end
                    got++;
                    prev_last = (got == n);
                end else begin
                    held = 1; hb = wr_byte; ha = wr_addr;
                end
            end
            @(negedge clk);
            if (poke) begin
                req_valid = 1'b0;
                poke = 0;
            end
            cyc++;
        end
        chk(got == n, {rq, " byte count"}, 64'(got), 64'(n));
        wr_ready = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!wr_valid && !done && req_ready, "R1 in reset",
            {wr_valid, done, req_ready}, 64'b001);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_valid && !done && req_ready, "R1 after reset",
            {wr_valid, done, req_ready}, 64'b001);
    endtask

    task automatic test_word_edges();
        run_job(64'hAAAA_BBBB_1122_3344, 32'h0000_1000, 1, 0, 1, 0, 0, "R3 left off0");
        run_job(64'hAAAA_BBBB_1122_3344, 32'h0000_1003, 1, 0, 1, 0, 0, "R3 left off3");
        run_job(64'hAAAA_BBBB_1122_3344, 32'h0000_1003, 1, 0, 0, 0, 0, "R3 right off3");
        run_job(64'hAAAA_BBBB_1122_3344, 32'h0000_1000, 1, 0, 0, 0, 0, "R3 right off0");
        run_job(64'h5566_7788_99AA_BBCC, 32'h0000_2000, 0, 0, 1, 0, 0, "R3 le left");
        run_job(64'h5566_7788_99AA_BBCC, 32'h0000_2000, 0, 0, 0, 0, 0, "R3 le right");
    endtask

    task automatic test_dword();
        run_job(64'h0102_0304_0506_0708, 32'hFFFF_FFF2, 1, 1, 1, 0, 0, "R4 be left");
        run_job(64'h0102_0304_0506_0708, 32'h0000_0005, 0, 1, 0, 0, 0, "R4 le right");
        run_job(64'h0102_0304_0506_0708, 32'h0000_0002, 0, 1, 1, 0, 0, "R4 le left");
    endtask

    task automatic test_stall_and_poke();
        run_job(64'hDEAD_BEEF_CAFE_F00D, 32'h0000_3000, 1, 1, 1, 1, 0, "R8 stall");
        run_job(64'hDEAD_BEEF_CAFE_F00D, 32'h0000_3007, 0, 1, 0, 1, 1, "R2 poke");
    endtask

    task automatic test_sweep();
        for (int v = 0; v < 2; v++)
            for (int b = 0; b < 2; b++)
                for (int l = 0; l < 2; l++)
                    for (int o = 0; o < (v ? 8 : 4); o++)
                        run_job(64'hF0E1_D2C3_B4A5_9687, 32'h0000_4000 + o,
                                b[0], v[0], l[0], 0, 0, "R3/R4 sweep");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_word_edges();
        test_dword();
        test_stall_and_poke();
        test_sweep();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule